// File: doc/BRIEF.md
# Capability-Checked Data Address Generator

This block turns a 64-bit data offset into a virtual address under the authority of a default data capability. The capability is presented on the ports as a validity tag, a sealed flag, read and write permission bits, a cursor, a lower bound and an upper limit. A request carries an access kind and an access-width code. The block adds the offset to the cursor and works out which bytes the access touches. It then validates the capability and the touched bytes.

A response appears one cycle after each request. It carries either the generated address or a single fault cause, together with the number of the capability register that faulted. The unaligned left and right forms for words and doublewords touch only the part of the word that lies on one side of the address. Those bytes alone are held against the bounds, and the address itself is passed on unchanged.

Top module: `cap_addr_gen`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle in which `req_valid` was high and is low otherwise; reset drives it low.
- R2: When `cap_tag` is 0 the cause is 2 (tag), whatever the other inputs are.
- R3: When the tag is set and `cap_sealed` is 1 the cause is 3 (sealed), ahead of any permission or bounds fault.
- R4: Access kind codes are 0 = load, 1 = store, 2 = fetch, 3 = reserved. On a valid, unsealed capability, a load without `cap_perm_load` gives cause 4 and a store without `cap_perm_store` gives cause 5. Fetch and reserved kinds give cause 6 (illegal kind). All three take precedence over bounds.
- R5: The address is `cap_cursor + req_offset`, wrapping modulo 2^64.
- R6: Width codes 0, 1, 2 and 3 are aligned accesses of 1, 2, 4 and 8 bytes starting at the address. Cause 1 (length) is raised if address + size exceeds `cap_top`, or if the address is below `cap_base`. The sum and `cap_top` are 65 bits wide, so a top of 2^64 is reachable.
- R7: Width code 4 (word-left) touches 4 − (addr mod 4) bytes from the address. Code 5 (word-right) touches (addr mod 4) + 1 bytes from the address rounded down to a multiple of 4. These bytes are bounds-checked as in R6.
- R8: Width code 6 (doubleword-left) touches 8 − (addr mod 8) bytes from the address. Code 7 (doubleword-right) touches (addr mod 8) + 1 bytes from the address rounded down to a multiple of 8. These bytes are bounds-checked as in R6.
- R9: For codes 4 to 7 a passing response returns the unmodified address, not the start of the touched span.
- R10: A response without fault has cause 0 and the address. A faulting response has `rsp_addr` = 0. `rsp_regnum` is 0 (the default data capability) on every response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 reserved) |
| req_width | input | 3 | Width code (0..3 aligned, 4 WL, 5 WR, 6 DL, 7 DR) |
| req_offset | input | 64 | Unsigned offset added to the cursor |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability sealed flag |
| cap_perm_load | input | 1 | Load permission |
| cap_perm_store | input | 1 | Store permission |
| cap_cursor | input | 64 | Capability cursor |
| cap_base | input | 64 | Lowest permitted byte address |
| cap_top | input | 65 | One past highest permitted byte address |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 64 | Generated address, 0 on fault |
| rsp_cause | output | 3 | Fault cause (0 none, 1 length, 2 tag, 3 sealed, 4 load perm, 5 store perm, 6 illegal kind) |
| rsp_regnum | output | 5 | Faulting capability register number |

## Verification
A capability fault and a bounds fault can both apply to a single request. So can a tag fault and a sealing fault. The bench forms requests that break several rules at once: an untagged, sealed capability with no permissions and an out-of-range offset, or a store lacking permission that also overruns the top. It judges each one by whether only the highest-ranked cause is reported. Unaligned left and right forms are also placed where the partial span fits but the full word would not, and the reverse, so that span and full-size checking give different outcomes.

// File: rtl/cag_pkg.sv
package cag_pkg;
   localparam logic [2:0] CAUSE_NONE    = 3'd0;
   localparam logic [2:0] CAUSE_LENGTH  = 3'd1;
   localparam logic [2:0] CAUSE_TAG     = 3'd2;
   localparam logic [2:0] CAUSE_SEAL    = 3'd3;
   localparam logic [2:0] CAUSE_PLOAD   = 3'd4;
   localparam logic [2:0] CAUSE_PSTORE  = 3'd5;
   localparam logic [2:0] CAUSE_ILLEGAL = 3'd6;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_RSVD  = 2'd3
   } kind_e;

   localparam logic [2:0] WID_WL = 3'd4;
   localparam logic [2:0] WID_WR = 3'd5;
   localparam logic [2:0] WID_DL = 3'd6;
   localparam logic [2:0] WID_DR = 3'd7;
endpackage

// File: rtl/cag_gate.sv
module cag_gate
   import cag_pkg::*;
(
   input  logic       tag,
   input  logic       sealed,
   input  logic       perm_load,
   input  logic       perm_store,
   input  logic [1:0] kind,
   output logic [2:0] gate_cause
);
   kind_e kind_q;
   assign kind_q = kind_e'(kind);

   always_comb begin
      if (!tag)
         gate_cause = CAUSE_TAG;
      else if (sealed)
         gate_cause = CAUSE_SEAL;
      else begin
         case (kind_q)
            KIND_LOAD:  gate_cause = perm_load  ? CAUSE_NONE : CAUSE_PLOAD;
            KIND_STORE: gate_cause = perm_store ? CAUSE_NONE : CAUSE_PSTORE;
            default:    gate_cause = CAUSE_ILLEGAL;
         endcase
      end
   end
endmodule

// File: rtl/cag_span.sv
module cag_span
   import cag_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [2:0]        width,
   output logic [ADDR_W-1:0] span_start,
   output logic [SIZE_W-1:0] span_size
);
   localparam int NGRAN = 2;

   logic [SIZE_W-1:0] l_size  [NGRAN];
   logic [SIZE_W-1:0] r_size  [NGRAN];
   logic [ADDR_W-1:0] r_start [NGRAN];

   for (genvar g = 0; g < NGRAN; g++) begin : g_gran
      localparam int LB   = 2 + g;
      localparam int GRAN = 1 << LB;
      logic [LB-1:0] ofs;
      assign ofs        = va[LB-1:0];
      assign l_size[g]  = SIZE_W'(GRAN) - SIZE_W'(ofs);
      assign r_size[g]  = SIZE_W'(ofs) + SIZE_W'(1);
      assign r_start[g] = {va[ADDR_W-1:LB], {LB{1'b0}}};
   end

   always_comb begin
      span_start = va;
      span_size  = SIZE_W'(1) << width[1:0];
      case (width)
         WID_WL: span_size = l_size[0];
         WID_WR: begin
            span_start = r_start[0];
            span_size  = r_size[0];
         end
         WID_DL: span_size = l_size[1];
         WID_DR: begin
            span_start = r_start[1];
            span_size  = r_size[1];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cag_bounds.sv
module cag_bounds #(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] span_start,
   input  logic [SIZE_W-1:0] span_size,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W:0]   top,
   output logic              out_of_bounds
);
   localparam int EXT_W = ADDR_W + 1;
   logic [EXT_W-1:0] span_end;

   assign span_end      = {1'b0, span_start} + EXT_W'(span_size);
   assign out_of_bounds = (span_end > top) || (span_start < base);
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen
   import cag_pkg::*;
#(
   parameter int ADDR_W          = 64,
   parameter int REG_W           = 5,
   parameter int DEFAULT_CAP_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [2:0]        req_width,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic              cap_tag,
   input  logic              cap_sealed,
   input  logic              cap_perm_load,
   input  logic              cap_perm_store,
   input  logic [ADDR_W-1:0] cap_cursor,
   input  logic [ADDR_W-1:0] cap_base,
   input  logic [ADDR_W:0]   cap_top,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [2:0]        rsp_cause,
   output logic [REG_W-1:0]  rsp_regnum
);
   localparam int SIZE_W = 4;

   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("cap_addr_gen: ADDR_W must be at least 8");
   end
   if (DEFAULT_CAP_IDX >= (1 << REG_W)) begin : g_bad_idx
      $error("cap_addr_gen: DEFAULT_CAP_IDX does not fit REG_W");
   end

   logic [ADDR_W-1:0] va;
   logic [ADDR_W-1:0] span_start;
   logic [SIZE_W-1:0] span_size;
   logic              oob;
   logic [2:0]        gate_cause;
   logic [2:0]        final_cause;

   assign va = cap_cursor + req_offset;

   cag_gate u_gate (
      .tag        (cap_tag),
      .sealed     (cap_sealed),
      .perm_load  (cap_perm_load),
      .perm_store (cap_perm_store),
      .kind       (req_kind),
      .gate_cause (gate_cause)
   );

   cag_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_span (
      .va         (va),
      .width      (req_width),
      .span_start (span_start),
      .span_size  (span_size)
   );

   cag_bounds #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bounds (
      .span_start    (span_start),
      .span_size     (span_size),
      .base          (cap_base),
      .top           (cap_top),
      .out_of_bounds (oob)
   );

   always_comb begin
      if (gate_cause != CAUSE_NONE) final_cause = gate_cause;
      else if (oob)                 final_cause = CAUSE_LENGTH;
      else                          final_cause = CAUSE_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_cause <= CAUSE_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_cause <= final_cause;
            rsp_addr  <= (final_cause == CAUSE_NONE) ? va : '0;
         end
      end
   end

   assign rsp_regnum = REG_W'(DEFAULT_CAP_IDX);

   p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_tag_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cap_tag) |=> (rsp_cause == CAUSE_TAG));
   p_seal_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cap_tag && cap_sealed) |=> (rsp_cause == CAUSE_SEAL));
   p_fetch_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cap_tag && !cap_sealed && req_kind[1]) |=> (rsp_cause == CAUSE_ILLEGAL));
   p_addr_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((rsp_cause != CAUSE_NONE) || (rsp_addr == $past(cap_cursor + req_offset))));
   p_fault_zero_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cause != CAUSE_NONE) |-> (rsp_addr == '0));
endmodule

// File: tb/tb_cap_addr_gen.sv
module tb_cap_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [2:0]  req_width = 3'd0;
   logic [63:0] req_offset = '0;
   logic        cap_tag = 1'b1;
   logic        cap_sealed = 1'b0;
   logic        cap_perm_load = 1'b1;
   logic        cap_perm_store = 1'b1;
   logic [63:0] cap_cursor = 64'h1000;
   logic [63:0] cap_base = 64'h1000;
   logic [64:0] cap_top = 65'h2000;
   logic        rsp_valid;
   logic [63:0] rsp_addr;
   logic [2:0]  rsp_cause;
   logic [4:0]  rsp_regnum;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   cap_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_width(req_width), .req_offset(req_offset), .cap_tag(cap_tag),
      .cap_sealed(cap_sealed), .cap_perm_load(cap_perm_load),
      .cap_perm_store(cap_perm_store), .cap_cursor(cap_cursor),
      .cap_base(cap_base), .cap_top(cap_top), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_cause(rsp_cause), .rsp_regnum(rsp_regnum)
   );

   task automatic set_cap(input logic t, input logic s, input logic pl, input logic ps,
                          input logic [63:0] cur, input logic [63:0] b, input logic [64:0] tp);
      cap_tag = t; cap_sealed = s; cap_perm_load = pl; cap_perm_store = ps;
      cap_cursor = cur; cap_base = b; cap_top = tp;
   endtask

   task automatic issue(input logic [1:0] k, input logic [2:0] w, input logic [63:0] ofs);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_width = w; req_offset = ofs;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input logic [2:0] ecause, input logic [63:0] eaddr);
      n_tests++;
      if (rsp_valid !== 1'b1 || rsp_cause !== ecause || rsp_addr !== eaddr || rsp_regnum !== 5'd0) begin
         n_fail++;
         $display("FAIL %s: valid=%0b cause=%0d addr=%h reg=%0d, expected valid=1 cause=%0d addr=%h reg=0",
                  req, rsp_valid, rsp_cause, rsp_addr, rsp_regnum, ecause, eaddr);
      end
   endtask

   task automatic run(input string req, input logic [1:0] k, input logic [2:0] w,
                      input logic [63:0] ofs, input logic [2:0] ecause, input logic [63:0] eaddr);
      issue(k, w, ofs);
      expect_rsp(req, ecause, eaddr);
   endtask

   task automatic t_reset();
      n_tests++;
      if (rsp_valid !== 1'b0 || rsp_cause !== 3'd0 || rsp_addr !== 64'd0) begin
         n_fail++;
         $display("FAIL R1 reset: valid=%0b cause=%0d addr=%h, expected 0 0 0", rsp_valid, rsp_cause, rsp_addr);
      end
   endtask

   task automatic t_aligned();
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R6 byte load",            2'd0, 3'd0, 64'h10,  3'd0, 64'h1010);
      run("R6 dword ends at top",    2'd1, 3'd3, 64'hFF8, 3'd0, 64'h1FF8);
      run("R6 dword over top",       2'd0, 3'd3, 64'hFF9, 3'd1, 64'h0);
      run("R6 word over top",        2'd0, 3'd2, 64'hFFD, 3'd1, 64'h0);
      run("R6 half inside",          2'd1, 3'd1, 64'hFFE, 3'd0, 64'h1FFE);
   endtask

   task automatic t_wrap();
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R5 wrap below base",      2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 64'h0);
      set_cap(1, 0, 1, 1, 64'h1000, 64'h0, 65'h2000);
      run("R5 wrap address",         2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 64'hFFF);
   endtask

   task automatic t_priority();
      set_cap(0, 1, 0, 0, 64'h1000, 64'h1000, 65'h2000);
      run("R2 tag over all",         2'd0, 3'd3, 64'h5000, 3'd2, 64'h0);
      set_cap(1, 1, 0, 0, 64'h1000, 64'h1000, 65'h2000);
      run("R3 seal over perm",       2'd1, 3'd3, 64'h5000, 3'd3, 64'h0);
      set_cap(1, 0, 0, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R4 load no perm",         2'd0, 3'd0, 64'h0,    3'd4, 64'h0);
      set_cap(1, 0, 1, 0, 64'h1000, 64'h1000, 65'h2000);
      run("R4 store no perm oob",    2'd1, 3'd3, 64'h5000, 3'd5, 64'h0);
      run("R4 load with perm",       2'd0, 3'd0, 64'h4,    3'd0, 64'h1004);
   endtask

   task automatic t_kind();
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R4 fetch illegal",        2'd2, 3'd2, 64'h0, 3'd6, 64'h0);
      run("R4 reserved illegal",     2'd3, 3'd2, 64'h0, 3'd6, 64'h0);
      set_cap(0, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R2 fetch untagged",       2'd2, 3'd2, 64'h0, 3'd2, 64'h0);
   endtask

   task automatic t_word_lr();
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R7 WL partial fits",      2'd0, 3'd4, 64'hFFD, 3'd0, 64'h1FFD);
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h1FFF);
      run("R7 WL over top",          2'd0, 3'd4, 64'hFFC, 3'd1, 64'h0);
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1001, 65'h2000);
      run("R7 WR start below base",  2'd1, 3'd5, 64'h3, 3'd1, 64'h0);
      run("R9 WR returns address",   2'd1, 3'd5, 64'h4, 3'd0, 64'h1004);
   endtask

   task automatic t_dword_lr();
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R8 DL partial fits",      2'd0, 3'd6, 64'hFFA, 3'd0, 64'h1FFA);
      run("R9 DR returns address",   2'd0, 3'd7, 64'hFFF, 3'd0, 64'h1FFF);
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h1FFF);
      run("R8 DL over top",          2'd0, 3'd6, 64'hFF9, 3'd1, 64'h0);
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1FF9, 65'h2000);
      run("R8 DR start below base",  2'd1, 3'd7, 64'hFFF, 3'd1, 64'h0);
   endtask

   task automatic t_top_limit();
      set_cap(1, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 65'h1_0000_0000_0000_0000);
      run("R6 top 2^64 fits",        2'd0, 3'd3, 64'h0, 3'd0, 64'hFFFF_FFFF_FFFF_FFF8);
      run("R6 top 2^64 overrun",     2'd0, 3'd3, 64'h1, 3'd1, 64'h0);
   endtask

   task automatic t_idle();
      set_cap(1, 0, 1, 1, 64'h1000, 64'h1000, 65'h2000);
      run("R1 single response",      2'd0, 3'd0, 64'h20, 3'd0, 64'h1020);
      @(negedge clk);
      n_tests++;
      if (rsp_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 idle: valid=%0b expected 0", rsp_valid);
      end
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_aligned();
      t_wrap();
      t_priority();
      t_kind();
      t_word_lr();
      t_dword_lr();
      t_top_limit();
      t_idle();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule